// File: doc/BRIEF.md
# SIMD Control/Status Register with Guarded Restore

This block keeps the 32-bit control/status word of a SIMD floating-point unit. The word carries six sticky exception flags, six matching mask bits and a few further control bits; the remaining positions are reserved and always read as zero.

A state-restore path writes the whole word at once. The write takes effect only when the operating system has enabled SIMD state handling. An image that sets any reserved bit is refused and answered with a general-protection fault pulse.

The arithmetic datapath sends one occurrence pulse per exception type. Each pulse sets its sticky flag. It also raises a numeric-error pulse when that exception is unmasked. A flag that is already set never produces an error by itself, even when a restore has just loaded it with its mask clear. Only a fresh occurrence of that exception does.

Top module: `simd_csr_restore`

## Requirements
- R1: After reset the register reads 0x0000_1F80, which means all six masks (bits 12:7) are set and all flags (bits 5:0) are clear. `gp_fault_o` and `num_err_o` are low after reset.
- R2: Bits 31:16 and bit 6 of `csr_o` read as zero at all times.
- R3: A restore with `os_en_i`=1 whose data has no reserved bit set is accepted. The written value, including bits 15:13, appears on `csr_o` one cycle after the strobe.
- R4: A restore with `os_en_i`=1 whose data has any reserved bit set leaves the register unchanged. It makes `gp_fault_o` high for exactly the one cycle after the strobe.
- R5: A restore with `os_en_i`=0 is ignored: the register is not updated and no fault is raised.
- R6: An occurrence pulse on `exc_i[k]` (k = 0..5) sets flag bit k of the register one cycle later, whatever the state of its mask.
- R7: `num_err_o` is high in the cycle after an occurrence pulse on `exc_i[k]` if mask bit 7+k was 0 when the pulse arrived. When the mask bit was 1, `num_err_o` stays low.
- R8: Restoring an image whose flag k is set and mask k is clear never raises `num_err_o`, during or after the load. The next occurrence pulse of exception k does raise it.
- R9: When an accepted restore and occurrence pulses arrive in the same cycle, the pulsed flags are merged into the restored value. The error decision uses the mask held before the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restore_i | input | 1 | Restore strobe, one cycle |
| restore_data_i | input | 32 | Image to load |
| os_en_i | input | 1 | Operating system has enabled SIMD state |
| exc_i | input | 6 | Exception occurrence pulses, bit k = exception k |
| csr_o | output | 32 | Current register value |
| gp_fault_o | output | 1 | General-protection fault pulse |
| num_err_o | output | 1 | Numeric error pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit word, six exception types, masks starting at bit 7 and the reserved range starting at bit 16. Under these values, single reserved bits at both ends of the reserved set (bit 6 and bit 31) can be tried against the fault path. The one-cycle timing of every output can also be checked exactly.

The bench also reaches the restore of a pending unmasked flag followed by a fresh occurrence. It covers the same-cycle collision of a restore with occurrence pulses in both mask directions.

// File: rtl/simd_csr_pkg.sv
package simd_csr_pkg;
  localparam int unsigned CSR_W      = 32;
  localparam int unsigned NUM_EXC    = 6;
  localparam int unsigned FLAG_LSB   = 0;
  localparam int unsigned MASK_LSB   = 7;
  localparam int unsigned RSV_HI_LSB = 16;
  localparam int unsigned RSV_BIT    = 6;

  typedef logic [CSR_W-1:0]   csr_t;
  typedef logic [NUM_EXC-1:0] exc_vec_t;

  function automatic csr_t calc_rsv_mask();
    csr_t m = '0;
    for (int i = 0; i < CSR_W; i++)
      m[i] = (i >= RSV_HI_LSB) || (i == RSV_BIT);
    return m;
  endfunction

  function automatic csr_t calc_reset_val();
    csr_t v = '0;
    for (int i = 0; i < NUM_EXC; i++) v[MASK_LSB+i] = 1'b1;
    return v;
  endfunction

  localparam csr_t RSV_MASK  = calc_rsv_mask();
  localparam csr_t CSR_RESET = calc_reset_val();
endpackage

// File: rtl/csr_load_gate.sv
module csr_load_gate
  import simd_csr_pkg::*;
(
  input  logic restore_i,
  input  logic os_en_i,
  input  csr_t data_i,
  output logic accept_o,
  output logic fault_o
);
  logic rsv_hit;

  assign rsv_hit  = |(data_i & RSV_MASK);
  assign accept_o = restore_i && os_en_i && !rsv_hit;
  assign fault_o  = restore_i && os_en_i && rsv_hit;
endmodule

// File: rtl/csr_exc_unit.sv
module csr_exc_unit
  import simd_csr_pkg::*;
(
  input  exc_vec_t exc_i,
  input  exc_vec_t mask_i,
  output exc_vec_t set_o,
  output logic     err_o
);
  exc_vec_t unmasked;

  for (genvar k = 0; k < NUM_EXC; k++) begin : g_exc
    assign set_o[k]    = exc_i[k];
    // error only on a fresh occurrence, never on a sticky flag
    assign unmasked[k] = exc_i[k] & ~mask_i[k];
  end

  assign err_o = |unmasked;
endmodule

// File: rtl/simd_csr_restore.sv
module simd_csr_restore
  import simd_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restore_i,
  input  logic [CSR_W-1:0]  restore_data_i,
  input  logic              os_en_i,
  input  logic [NUM_EXC-1:0] exc_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic              gp_fault_o,
  output logic              num_err_o
);
  csr_t     csr_q, csr_d, base;
  logic     accept, fault, err;
  exc_vec_t flag_set;

  csr_load_gate u_gate (
    .restore_i (restore_i),
    .os_en_i   (os_en_i),
    .data_i    (restore_data_i),
    .accept_o  (accept),
    .fault_o   (fault)
  );

  csr_exc_unit u_exc (
    .exc_i  (exc_i),
    .mask_i (csr_q[MASK_LSB +: NUM_EXC]),
    .set_o  (flag_set),
    .err_o  (err)
  );

  always_comb begin
    base  = accept ? (restore_data_i & ~RSV_MASK) : csr_q;
    csr_d = base;
    csr_d[FLAG_LSB +: NUM_EXC] = base[FLAG_LSB +: NUM_EXC] | flag_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q      <= CSR_RESET;
      gp_fault_o <= 1'b0;
      num_err_o  <= 1'b0;
    end else begin
      csr_q      <= csr_d;
      gp_fault_o <= fault;
      num_err_o  <= err;
    end
  end

  assign csr_o = csr_q;
endmodule

// File: rtl/simd_csr_restore_chk.sv
module simd_csr_restore_chk
  import simd_csr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              restore_i,
  input logic [CSR_W-1:0]  restore_data_i,
  input logic              os_en_i,
  input logic [NUM_EXC-1:0] exc_i,
  input logic [CSR_W-1:0]  csr_o,
  input logic              gp_fault_o,
  input logic              num_err_o
);
  // R2
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o & RSV_MASK) == '0);

  // R4
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && os_en_i && |(restore_data_i & RSV_MASK)) |=> gp_fault_o);

  // R4
  fault_keep_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && os_en_i && |(restore_data_i & RSV_MASK))
      |=> csr_o[CSR_W-1:MASK_LSB] == $past(csr_o[CSR_W-1:MASK_LSB]));

  // R5
  os_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !os_en_i) |=> !gp_fault_o);

  // R7
  err_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(exc_i & ~csr_o[MASK_LSB +: NUM_EXC]) |=> num_err_o);

  // R8
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(exc_i & ~csr_o[MASK_LSB +: NUM_EXC])) |=> !num_err_o);

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i != '0) |=> ((csr_o[FLAG_LSB +: NUM_EXC] & $past(exc_i)) == $past(exc_i)));
endmodule

bind simd_csr_restore simd_csr_restore_chk i_chk (.*);

// File: tb/test_simd_csr_restore.sv
module test_simd_csr_restore;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        restore_i = 1'b0;
  logic [31:0] restore_data_i = '0;
  logic        os_en_i = 1'b1;
  logic [5:0]  exc_i = '0;
  logic [31:0] csr_o;
  logic        gp_fault_o, num_err_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  simd_csr_restore i_simd_csr_restore (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, land on next negedge with outputs registered
  task automatic step(logic rs, logic os, logic [31:0] d, logic [5:0] e);
    @(negedge clk_i);
    restore_i = rs; os_en_i = os; restore_data_i = d; exc_i = e;
    @(negedge clk_i);
    restore_i = 0; os_en_i = 1; restore_data_i = '0; exc_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 csr", csr_o, 32'h1F80);
    chk("R1 fault", gp_fault_o, 0);
    chk("R1 err", num_err_o, 0);
  endtask

  task automatic t_restore_ok();
    step(1, 1, 32'h0000_A03F, 0);
    chk("R3 csr", csr_o, 32'h0000_A03F);
    chk("R8 no err on load", num_err_o, 0);
    step(0, 1, 0, 0);
    chk("R8 no err after load", num_err_o, 0);
    chk("R2 rsv", csr_o & 32'hFFFF_0040, 0);
    step(0, 1, 0, 6'b000100);
    chk("R8 fresh occurrence err", num_err_o, 1);
    chk("R6 flag kept", csr_o, 32'h0000_A03F);
    step(0, 1, 0, 0);
    chk("R7 pulse ends", num_err_o, 0);
  endtask

  task automatic t_reserved();
    step(1, 1, 32'h0000_1F80, 0);
    step(1, 1, 32'h0000_0040, 0);
    chk("R4 fault bit6", gp_fault_o, 1);
    chk("R4 unchanged bit6", csr_o, 32'h1F80);
    step(0, 1, 0, 0);
    chk("R4 single pulse", gp_fault_o, 0);
    step(1, 1, 32'h8000_0000, 0);
    chk("R4 fault bit31", gp_fault_o, 1);
    chk("R4 unchanged bit31", csr_o, 32'h1F80);
  endtask

  task automatic t_os_off();
    step(1, 0, 32'h0000_0000, 0);
    chk("R5 csr", csr_o, 32'h1F80);
    chk("R5 fault", gp_fault_o, 0);
    step(1, 0, 32'h0001_0000, 0);
    chk("R5 rsv no fault", gp_fault_o, 0);
  endtask

  task automatic t_masking();
    step(0, 1, 0, 6'b001000);
    chk("R6 masked flag", csr_o, 32'h1F88);
    chk("R7 masked no err", num_err_o, 0);
    step(1, 1, 32'h0000_1F00, 0);
    step(0, 1, 0, 6'b000001);
    chk("R7 unmasked err", num_err_o, 1);
    chk("R6 flag0", csr_o, 32'h1F01);
    step(0, 1, 0, 6'b000010);
    chk("R7 masked exc1", num_err_o, 0);
    chk("R6 flag1", csr_o, 32'h1F03);
  endtask

  task automatic t_collide();
    step(1, 1, 32'h0000_1F80, 0);
    step(1, 1, 32'h0000_0000, 6'b010000);
    chk("R9 merged", csr_o, 32'h0000_0010);
    chk("R9 old mask set", num_err_o, 0);
    step(1, 1, 32'h0000_1F80, 6'b010000);
    chk("R9 merged2", csr_o, 32'h0000_1F90);
    chk("R9 old mask clear", num_err_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_restore_ok();
    t_reserved();
    t_os_off();
    t_masking();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule